// File: doc/BRIEF.md
# Relocating Executable Loader Engine

This engine prepares a program image for execution once the image has been copied into byte-addressable RAM at some load address. Software supplies the load address, the image length in bytes and a one-cycle start pulse. The engine walks the image header, verifies that the image is in the expected executable format, and records the allocation preference held in the header. It then goes through the relocation list and turns each program-relative address stored in the image into an absolute address.

An image starts with a six-byte header: a three-character signature, a flags byte and a 16-bit relocation count N. A list of N 16-bit program-relative offsets follows the header, and the program's first byte follows the list at image offset 6 + 2N. For every listed offset the engine reads the 16-bit word at that offset of the program, adds the absolute address of the program's first byte, and writes the sum back in place. At the end it gives the address the caller should jump to. The engine reaches memory through a single-port synchronous byte interface with one cycle of read latency. It makes one access per cycle, and a read and a write never share a cycle.

Top module: `relocating_loader`

## Requirements
- R1: Image bytes 0, 1 and 2 must hold 0x4F, 0x44 and 0x59 ("ODY"). If any of them differs, the run ends with `error` high, `err_kind` = 1 and `entry_addr` = 0, and nothing is written to memory.
- R2: `alloc_pref` equals bits [1:0] of image byte 3 (the flags byte). It is valid from `done` until the next accepted start.
- R3: The relocation count N is taken from image byte 4 (low) and byte 5 (high). Relocation entry k is the little-endian 16-bit word at image offsets 6+2k (low) and 7+2k (high), and entries are processed in order k = 0 .. N-1.
- R4: For each entry with offset `off`, the little-endian word at absolute address base+6+2N+off (low byte) and the next address (high byte) is replaced by word + base + 6 + 2N, modulo 2^16. All other bytes of the image and the bytes after it are left unchanged.
- R5: On a successful run, `entry_addr` equals (base + 6 + 2N) mod 2^16 when `done` is high, and holds that value until the next accepted start.
- R6: With N = 0 the run finishes with no error and no memory writes.
- R7: If 6 + 2N + off + 2 > `image_len` for an entry, the run stops at that entry with `error` high, `err_kind` = 2 and `entry_addr` = 0. Earlier entries stay patched, and this entry and later ones are not touched. A word that ends exactly on the last image byte is patched normally.
- R8: `busy` goes high in the cycle after an accepted start and stays high up to and including the single cycle in which `done` is high. It is low in the cycle after that. A `start` that arrives while `busy` is high is ignored.
- R9: `mem_rdata` is sampled one cycle after a `mem_rd` request. `mem_rd` and `mem_wr` are never high in the same cycle, and `mem_wr` is only high while `busy` is high.
- R10: An image loaded at 0xE000 with N = 3 and a listed word holding 0x000C ends with that word holding 0xE018, and `entry_addr` = 0xE00C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to process an image |
| base_addr | input | 16 | Absolute address of image byte 0 |
| image_len | input | 16 | Image length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse that ends a run |
| error | output | 1 | Last run failed |
| err_kind | output | 2 | 0 none, 1 bad signature, 2 offset out of range |
| alloc_pref | output | 2 | Allocation preference taken from the flags byte |
| entry_addr | output | 16 | Absolute address of the program's first byte |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |

## Verification
The assertions check on every cycle that reads and writes stay mutually exclusive and fall inside busy, that the two halves of a patched word go to consecutive addresses in consecutive cycles, and that `busy` holds until `done` and drops after it. They also check that a signature failure or an empty relocation list leaves memory unwritten. Only the bench scenarios can show that the patched values and the entry address are arithmetically correct. The same goes for the exact place where a range failure stops the walk, the wrap at the top of the address space, and the behaviour of a start that arrives during a run. The bench checks these by comparing the whole image region against a model that it computes itself.

// File: rtl/ldr_pkg.sv
// Shared constants and types for the relocating loader.
// Assumes a fixed header: 3 signature bytes, 1 flags byte, 16-bit count.
package ldr_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int HDR_BYTES = 6;
    localparam int SIG_LEN   = 3;
    localparam int LANES     = WORD_W / BYTE_W;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR_REQ,
        S_HDR_CAP,
        S_CNT_CHK,
        S_TBL_REQ,
        S_TBL_CAP,
        S_RNG_CHK,
        S_WRD_REQ,
        S_WRD_CAP,
        S_WR_LO,
        S_WR_HI,
        S_FIN
    } ldr_state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIG   = 2'd1,
        ERR_RANGE = 2'd2
    } ldr_err_t;

    // Expected signature byte at header position i
    function automatic logic [BYTE_W-1:0] sig_byte(input int unsigned i);
        case (i)
            0:       sig_byte = 8'h4F;
            1:       sig_byte = 8'h44;
            default: sig_byte = 8'h59;
        endcase
    endfunction
endpackage

// File: rtl/ldr_hdr_parse.sv
// Header parser: compares the signature bytes as they arrive, and keeps
// the allocation bits and the relocation count.
// Assumes each header byte is presented once with cap_en, index in idx.
module ldr_hdr_parse
    import ldr_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic              sig_bad,
    output logic [1:0]        alloc_pref,
    output logic [WORD_W-1:0] count
);
    localparam int MW = 4;

    logic [MW-1:0] match;

    // One comparator per signature position, padded to a power of two
    for (genvar g = 0; g < MW; g++) begin : g_sig
        if (g < SIG_LEN) begin : g_cmp
            assign match[g] = (din == sig_byte(g));
        end else begin : g_pad
            assign match[g] = 1'b1;
        end
    end

    // Signature failure only while a signature position is captured
    always_comb begin
        sig_bad = cap_en && (idx < IDX_W'(SIG_LEN)) && !match[idx[1:0]];
    end

    // Keep flags and count bytes
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            alloc_pref <= '0;
            count      <= '0;
        end else if (cap_en) begin
            if (idx == IDX_W'(3)) alloc_pref <= din[1:0];
            if (idx == IDX_W'(4)) count[BYTE_W-1:0] <= din;
            if (idx == IDX_W'(5)) count[WORD_W-1:BYTE_W] <= din;
        end
    end
endmodule

// File: rtl/ldr_word_cap.sv
// Assembles a little-endian 16-bit word from two byte captures.
// Assumes the low lane is captured with hi_lane=0, the high lane with 1.
module ldr_word_cap
    import ldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_en,
    input  logic              hi_lane,
    input  logic [BYTE_W-1:0] din,
    output logic [WORD_W-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Load this byte lane when selected
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                word[g*BYTE_W +: BYTE_W] <= '0;
            end else if (cap_en && (hi_lane == g[0])) begin
                word[g*BYTE_W +: BYTE_W] <= din;
            end
        end
    end
endmodule

// File: rtl/ldr_reloc_math.sv
// Address and value arithmetic for the relocation walk. Purely combinational.
// Assumes addresses and words wrap modulo 2^ADDR_W; the range check is exact.
module ldr_reloc_math
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] img_len,
    input  logic [WORD_W-1:0] count,
    input  logic [WORD_W-1:0] ent_idx,
    input  logic [WORD_W-1:0] offset,
    input  logic [WORD_W-1:0] word,
    output logic [ADDR_W-1:0] first_abs,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [WORD_W-1:0] patched,
    output logic              range_bad
);
    localparam int RW = WORD_W + 3;

    logic [ADDR_W-1:0] first_off;
    logic [RW-1:0]     first_ext;
    logic [RW-1:0]     word_end;

    // Program start offset and its absolute address
    always_comb begin
        first_off = ADDR_W'(HDR_BYTES) + ADDR_W'({count, 1'b0});
        first_abs = base + first_off;
        tbl_addr  = base + ADDR_W'(HDR_BYTES) + ADDR_W'({ent_idx, 1'b0});
        tgt_addr  = first_abs + ADDR_W'(offset);
        patched   = word + WORD_W'(first_abs);
    end

    // Exact-width bound check of the target word against the image length
    always_comb begin
        first_ext = RW'(HDR_BYTES) + (RW'(count) << 1);
        word_end  = first_ext + RW'(offset) + RW'(2);
        range_bad = word_end > RW'(img_len);
    end
endmodule

// File: rtl/relocating_loader.sv
// Relocating loader top: sequences header parsing, relocation table walk
// and read-modify-write patching over a single-port byte memory with
// one-cycle read latency. One memory access per cycle.
module relocating_loader
    import ldr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] image_len,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_kind,
    output logic [1:0]        alloc_pref,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(HDR_BYTES + 1);

    ldr_state_t        state;
    ldr_err_t          err_q;
    logic [IDX_W-1:0]  hdr_idx;
    logic              lane;
    logic [WORD_W-1:0] ent_idx;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] entry_q;
    logic              accept;
    logic              sig_bad;
    logic [WORD_W-1:0] count;
    logic [WORD_W-1:0] off_w;
    logic [WORD_W-1:0] data_w;
    logic [ADDR_W-1:0] first_abs;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [WORD_W-1:0] patched;
    logic              range_bad;
    logic              seen_wr;

    assign accept = (state == S_IDLE) && start;

    ldr_hdr_parse #(.IDX_W(IDX_W)) hdr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .cap_en     (state == S_HDR_CAP),
        .idx        (hdr_idx),
        .din        (mem_rdata),
        .sig_bad    (sig_bad),
        .alloc_pref (alloc_pref),
        .count      (count)
    );

    ldr_word_cap off_cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .cap_en  (state == S_TBL_CAP),
        .hi_lane (lane),
        .din     (mem_rdata),
        .word    (off_w)
    );

    ldr_word_cap dat_cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .cap_en  (state == S_WRD_CAP),
        .hi_lane (lane),
        .din     (mem_rdata),
        .word    (data_w)
    );

    ldr_reloc_math #(.ADDR_W(ADDR_W)) math_i (
        .base      (base_q),
        .img_len   (len_q),
        .count     (count),
        .ent_idx   (ent_idx),
        .offset    (off_w),
        .word      (data_w),
        .first_abs (first_abs),
        .tbl_addr  (tbl_addr),
        .tgt_addr  (tgt_addr),
        .patched   (patched),
        .range_bad (range_bad)
    );

    // Memory request decode from the current state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_HDR_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = base_q + ADDR_W'(hdr_idx);
            end
            S_TBL_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = tbl_addr + ADDR_W'(lane);
            end
            S_WRD_REQ: begin
                mem_rd   = 1'b1;
                mem_addr = tgt_addr + ADDR_W'(lane);
            end
            S_WR_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = tgt_addr;
                mem_wdata = patched[BYTE_W-1:0];
            end
            S_WR_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = tgt_addr + ADDR_W'(1);
                mem_wdata = patched[WORD_W-1:BYTE_W];
            end
            default: ;
        endcase
    end

    // Control sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            err_q   <= ERR_NONE;
            hdr_idx <= '0;
            lane    <= 1'b0;
            ent_idx <= '0;
            base_q  <= '0;
            len_q   <= '0;
            entry_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        base_q  <= base_addr;
                        len_q   <= image_len;
                        err_q   <= ERR_NONE;
                        entry_q <= '0;
                        hdr_idx <= '0;
                        lane    <= 1'b0;
                        ent_idx <= '0;
                        state   <= S_HDR_REQ;
                    end
                end
                S_HDR_REQ: state <= S_HDR_CAP;
                S_HDR_CAP: begin
                    if (sig_bad) begin
                        err_q <= ERR_SIG;
                        state <= S_FIN;
                    end else if (hdr_idx == IDX_W'(HDR_BYTES - 1)) begin
                        state <= S_CNT_CHK;
                    end else begin
                        hdr_idx <= hdr_idx + IDX_W'(1);
                        state   <= S_HDR_REQ;
                    end
                end
                S_CNT_CHK: begin
                    entry_q <= first_abs;
                    state   <= (count == '0) ? S_FIN : S_TBL_REQ;
                end
                S_TBL_REQ: state <= S_TBL_CAP;
                S_TBL_CAP: begin
                    lane  <= !lane;
                    state <= lane ? S_RNG_CHK : S_TBL_REQ;
                end
                S_RNG_CHK: begin
                    if (range_bad) begin
                        err_q   <= ERR_RANGE;
                        entry_q <= '0;
                        state   <= S_FIN;
                    end else begin
                        state <= S_WRD_REQ;
                    end
                end
                S_WRD_REQ: state <= S_WRD_CAP;
                S_WRD_CAP: begin
                    lane  <= !lane;
                    state <= lane ? S_WR_LO : S_WRD_REQ;
                end
                S_WR_LO: state <= S_WR_HI;
                S_WR_HI: begin
                    if ((ent_idx + WORD_W'(1)) == count) begin
                        state <= S_FIN;
                    end else begin
                        ent_idx <= ent_idx + WORD_W'(1);
                        state   <= S_TBL_REQ;
                    end
                end
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output status
    always_comb begin
        busy       = (state != S_IDLE);
        done       = (state == S_FIN);
        err_kind   = err_q;
        error      = (err_q != ERR_NONE);
        entry_addr = entry_q;
    end

    // Observation only: any write since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n || accept) seen_wr <= 1'b0;
        else if (mem_wr)      seen_wr <= 1'b1;
    end

    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_wr_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> busy);
    p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_wr_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
    p_sig_no_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_kind == ERR_SIG) |-> !seen_wr);
    p_zero_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error && count == '0) |-> !seen_wr);
endmodule

// File: tb/relocating_loader_tb.sv
module relocating_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] image_len = '0;
    logic        busy, done, error;
    logic [1:0]  err_kind, alloc_pref;
    logic [15:0] entry_addr, mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic        ld_en = 1'b0;
    logic [8:0]  ld_a = '0;
    logic [7:0]  ld_d = '0;
    logic [7:0]  ram [0:511];

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] img [0:255];
    logic [7:0] expv[0:255];

    always #10 clk = !clk;

    relocating_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .image_len(image_len), .busy(busy), .done(done), .error(error),
        .err_kind(err_kind), .alloc_pref(alloc_pref), .entry_addr(entry_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one-cycle read latency, plus a bench load port
    always @(posedge clk) begin
        if (ld_en)       ram[ld_a] <= ld_d;
        else if (mem_wr) ram[mem_addr[8:0]] <= mem_wdata;
        if (mem_rd)      mem_rdata <= ram[mem_addr[8:0]];
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_w(input int at, input int v);
        img[at]   = 8'(v);
        img[at+1] = 8'(v >> 8);
    endtask

    // Builds header, table and program bytes for n entries
    task automatic make_image(input int n, input int flags, input int plen, input int seed);
        int first;
        first = 6 + 2*n;
        for (int i = 0; i < 256; i++) img[i] = 8'hA5;
        img[0] = 8'h4F; img[1] = 8'h44; img[2] = 8'h59;
        img[3] = 8'(flags);
        set_w(4, n);
        for (int k = 0; k < n; k++) set_w(6 + 2*k, (k*7 + seed) % (plen - 1));
        for (int j = 0; j < plen; j++) img[first + j] = 8'(j*13 + seed*29 + 3);
    endtask

    // Loads the image, runs, and compares everything against a bench model
    task automatic run(input string tag, input int base, input int len, input int glitch);
        int n, first, ek, ent, off, idx, w, cyc, sawlow;
        for (int i = 0; i < len + 4; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_a = 9'(base + i); ld_d = img[i];
        end
        @(negedge clk); ld_en = 1'b0;
        for (int i = 0; i < 256; i++) expv[i] = img[i];
        n = {img[5], img[4]};
        first = 6 + 2*n;
        ek = 0;
        ent = (base + first) & 16'hFFFF;
        if (img[0] != 8'h4F || img[1] != 8'h44 || img[2] != 8'h59) begin
            ek = 1; ent = 0;
        end else begin
            for (int k = 0; k < n; k++) begin
                off = {img[7 + 2*k], img[6 + 2*k]};
                if (first + off + 2 > len) begin ek = 2; ent = 0; break; end
                idx = first + off;
                w = ({expv[idx+1], expv[idx]} + base + first) & 16'hFFFF;
                expv[idx] = 8'(w); expv[idx+1] = 8'(w >> 8);
            end
        end
        base_addr = 16'(base); image_len = 16'(len); start = 1'b1;
        @(negedge clk); start = 1'b0;
        base_addr = 16'h0BAD;
        cyc = 0; sawlow = 0;
        while (!done && cyc < 5000) begin
            if (!busy) sawlow = 1;
            if (glitch != 0 && cyc == 4) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk({tag, " R8 busy until done"}, sawlow, 0);
        chk({tag, " R8 done seen"}, int'(done), 1);
        chk({tag, " R7/R1 err_kind"}, int'(err_kind), ek);
        chk({tag, " R1/R7 error"}, int'(error), int'(ek != 0));
        chk({tag, " R5 entry_addr"}, int'(entry_addr), ent);
        if (ek != 1) chk({tag, " R2 alloc_pref"}, int'(alloc_pref), img[3] & 3);
        @(negedge clk);
        chk({tag, " R8 single done"}, int'(done), 0);
        chk({tag, " R8 idle after"}, int'(busy), 0);
        chk({tag, " R5 entry held"}, int'(entry_addr), ent);
        for (int i = 0; i < len + 4; i++)
            chk({tag, " R4 memory byte"}, int'(ram[9'(base + i)]), int'(expv[i]));
    endtask

    initial begin
        int bases[4];
        bases[0] = 16'h0000; bases[1] = 16'hE000; bases[2] = 16'h1234; bases[3] = 16'hFFF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R1 reset error", int'(error), 0);
        chk("R9 reset mem_rd", int'(mem_rd), 0);
        chk("R9 reset mem_wr", int'(mem_wr), 0);

        // R10: worked example at 0xE000, three entries
        make_image(3, 2, 16, 0);
        set_w(6, 16'h0002); set_w(8, 16'h0007); set_w(10, 16'h000D);
        set_w(12 + 2, 16'h000C); set_w(12 + 7, 16'h000F); set_w(12 + 13, 16'h0005);
        run("R10 example", 16'hE000, 28, 0);
        chk("R10 patched lab1", {ram[9'h00F], ram[9'h00E]}, 16'hE018);
        chk("R10 patched lab2", {ram[9'h01A], ram[9'h019]}, 16'hE011);
        chk("R3 second entry", {ram[9'h014], ram[9'h013]}, 16'hE01B);

        // R3 R4 R5 R6 R2: sweep of counts, bases and flags
        for (int n = 0; n < 6; n++)
            for (int b = 0; b < 4; b++) begin
                make_image(n, (n + b) & 3, 10 + n, n + b);
                run("R4 sweep", bases[b], 6 + 2*n + 10 + n, 0);
            end

        // R6: empty table, explicit
        make_image(0, 1, 4, 1);
        run("R6 zero count", 16'h4000, 10, 0);

        // R1: each signature position corrupted
        for (int p = 0; p < 3; p++) begin
            make_image(2, 0, 8, p);
            img[p] = img[p] ^ 8'h20;
            run("R1 bad signature", 16'h2000, 18, 0);
        end

        // R7: boundary entry accepted, next entry one byte too far
        make_image(3, 3, 10, 0);
        set_w(6, 8);
        set_w(8, 9);
        set_w(10, 0);
        run("R7 range stop", 16'h0100, 22, 0);
        make_image(1, 3, 10, 2);
        set_w(6, 8);
        run("R7 boundary ok", 16'h0100, 18, 0);

        // R8: start during a run is ignored
        make_image(4, 1, 12, 5);
        run("R8 start while busy", 16'h3000, 26, 1);

        // R4: wrap of the sum past 0xFFFF
        make_image(2, 0, 6, 0);
        set_w(6, 0); set_w(8, 2);
        set_w(10, 16'hFFFE); set_w(12, 16'h8000);
        run("R4 sum wrap", 16'hFFF0, 16, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule